// File: doc/BRIEF.md
# Preemptive Priority Interrupt Controller

This block arbitrates interrupt requests for a single processor core. Requests come from level-sensitive peripheral lines and from a small set of request bits that software sets and clears through register writes. Each source carries a 4-bit priority that software can change at any time. The controller picks the highest-priority pending source and offers it to the core with its vector number. A source wins only if its priority lies strictly above the core's current priority.

When the core acknowledges a request, the current priority is saved on a last-in first-out stack. The priority of the accepted source then becomes the new current priority, so only a more urgent source can preempt it. An end-of-interrupt write restores the saved level. Software may also write the current priority directly to mask everything up to a ceiling. A software source lets a handler hand its remaining work to a lower level and then return. The non-maskable input is not arbitrated: it goes straight through to its own output.

Top module: `prio_intc`

## Requirements
- R1: There are 16 levels (0 to 15). `irq_o` is high with `irq_vec_o` equal to the source index and `irq_prio_o` equal to its priority when that pending source has a priority strictly greater than the current priority. The outputs are registered and follow a state or input change one clock later.
- R2: When several pending sources share the highest qualifying priority, the one with the lowest index is presented.
- R3: A source whose priority is 0 never raises `irq_o`.
- R4: A one-cycle `ack_i` while `irq_o` is high pushes the current priority onto a 16-entry stack and makes the presented priority the current priority. An `ack_i` while `irq_o` is low has no effect.
- R5: A write to address 0x01 (end of interrupt) pops the stack into the current priority. On an empty stack it sets the current priority to 0.
- R6: A write to address 0x00 loads the current priority from `reg_wdata[3:0]` without touching the stack. Sources at or below the written level are then masked.
- R7: A write to address 0x10+i sets the priority of source i from `reg_wdata[3:0]` at run time.
- R8: Sources 0 to NUM_HW-1 follow `hw_req_i`. Sources NUM_HW to NUM_HW+NUM_SW-1 are software bits. A write to 0x02 sets the bits that are 1 in `reg_wdata`, and a write to 0x03 clears them. Acknowledging a software source leaves its bit set.
- R9: `nmi_o` equals `nmi_i` in the same cycle, independent of all other state.
- R10: After reset, the current priority, all source priorities and all software bits are 0, the stack is empty and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_req_i | input | NUM_HW | Level peripheral request lines |
| nmi_i | input | 1 | Non-maskable request in |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register write address |
| reg_wdata | input | max(NUM_SW,4) | Register write data |
| ack_i | input | 1 | Core acknowledge strobe |
| irq_o | output | 1 | Maskable request to core |
| irq_vec_o | output | clog2(NUM_HW+NUM_SW) | Vector (source index) of presented request |
| irq_prio_o | output | 4 | Priority of presented request |
| cur_prio_o | output | 4 | Current priority level |
| nmi_o | output | 1 | Non-maskable request to core |

## Verification
A wrong current level or stack entry shows at the ports as a request that stays masked, or one that is presented when it should be masked. This appears on `irq_o` one clock after the end-of-interrupt or acknowledge that exposed it. A corrupted stack entry surfaces only when that entry is popped, so the checks walk through nested acknowledges and their returns, including a pop from an empty stack. Tie-breaking and the priority-0 rule are checked by giving several live sources equal or zero priorities and reading the vector.

// File: rtl/prio_intc_pkg.sv
package prio_intc_pkg;
  localparam int PRIO_W    = 4;
  localparam int LEVELS    = 1 << PRIO_W;
  localparam int ADDR_W    = 6;
  localparam int ADR_CUR   = 0;
  localparam int ADR_EOI   = 1;
  localparam int ADR_SWSET = 2;
  localparam int ADR_SWCLR = 3;
  localparam int ADR_PRIO0 = 16;
  typedef logic [PRIO_W-1:0] prio_t;
endpackage

// File: rtl/intc_src_regs.sv
module intc_src_regs
  import prio_intc_pkg::*;
#(
  parameter int NUM_HW = 8,
  parameter int NUM_SW = 4,
  parameter int DATA_W = 4,
  localparam int NSRC  = NUM_HW + NUM_SW
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [DATA_W-1:0]      wdata,
  output logic [NSRC*PRIO_W-1:0] prio_flat,
  output logic [NUM_SW-1:0]      sw_pend
);
  logic set_hit, clr_hit;
  assign set_hit = we && (addr == ADDR_W'(ADR_SWSET));
  assign clr_hit = we && (addr == ADDR_W'(ADR_SWCLR));

  genvar gi;
  generate
    for (gi = 0; gi < NSRC; gi++) begin : g_prio
      always_ff @(posedge clk) begin
        if (rst)
          prio_flat[gi*PRIO_W +: PRIO_W] <= '0;
        else if (we && addr == ADDR_W'(ADR_PRIO0 + gi))
          prio_flat[gi*PRIO_W +: PRIO_W] <= wdata[PRIO_W-1:0];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)
      sw_pend <= '0;
    else if (set_hit)
      sw_pend <= sw_pend | wdata[NUM_SW-1:0];
    else if (clr_hit)
      sw_pend <= sw_pend & ~wdata[NUM_SW-1:0];
  end

  // R8: cleared software bits read as zero on the next cycle
  a_r8_sw_clear: assert property (@(posedge clk) disable iff (rst)
    clr_hit |=> ((sw_pend & $past(wdata[NUM_SW-1:0])) == '0));
endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
  import prio_intc_pkg::*;
#(
  parameter int NSRC  = 12,
  localparam int VEC_W = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0]        pend,
  input  logic [NSRC*PRIO_W-1:0] prio_flat,
  input  prio_t                  cur_prio,
  output logic                   found,
  output logic [VEC_W-1:0]       win_vec,
  output prio_t                  win_prio
);
  // Strict compare keeps the lowest index on ties and rejects level 0.
  always_comb begin
    found    = 1'b0;
    win_vec  = '0;
    win_prio = cur_prio;
    for (int i = 0; i < NSRC; i++) begin
      if (pend[i] && (prio_flat[i*PRIO_W +: PRIO_W] > win_prio)) begin
        found    = 1'b1;
        win_vec  = VEC_W'(i);
        win_prio = prio_flat[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/intc_prio_stack.sv
module intc_prio_stack
  import prio_intc_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH + 1)
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  push,
  input  prio_t push_data,
  input  logic  pop,
  output prio_t top,
  output logic  empty
);
  prio_t            mem [DEPTH];
  logic [PTR_W-1:0] cnt;
  logic             full;

  assign empty = (cnt == '0);
  assign full  = (cnt == PTR_W'(DEPTH));
  assign top   = empty ? '0 : mem[cnt - 1'b1];

  always_ff @(posedge clk) begin
    if (push && !full)
      mem[cnt[$clog2(DEPTH)-1:0]] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (push && !full)
      cnt <= cnt + 1'b1;
    else if (pop && !empty)
      cnt <= cnt - 1'b1;
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import prio_intc_pkg::*;
#(
  parameter int NUM_HW = 8,
  parameter int NUM_SW = 4,
  localparam int NSRC   = NUM_HW + NUM_SW,
  localparam int VEC_W  = (NSRC > 1) ? $clog2(NSRC) : 1,
  localparam int DATA_W = (NUM_SW > PRIO_W) ? NUM_SW : PRIO_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_HW-1:0] hw_req_i,
  input  logic              nmi_i,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              ack_i,
  output logic              irq_o,
  output logic [VEC_W-1:0]  irq_vec_o,
  output logic [PRIO_W-1:0] irq_prio_o,
  output logic [PRIO_W-1:0] cur_prio_o,
  output logic              nmi_o
);
  logic [NSRC*PRIO_W-1:0] prio_flat;
  logic [NUM_SW-1:0]      sw_pend;
  logic [NSRC-1:0]        pend;
  logic                   found;
  logic [VEC_W-1:0]       win_vec;
  prio_t                  win_prio;
  prio_t                  cur_prio, stk_top;
  logic                   stk_empty;
  logic                   ack_take, eoi_hit, cur_hit;

  assign nmi_o = nmi_i;
  assign pend  = {sw_pend, hw_req_i};

  intc_src_regs #(.NUM_HW(NUM_HW), .NUM_SW(NUM_SW), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .prio_flat(prio_flat), .sw_pend(sw_pend)
  );

  intc_arbiter #(.NSRC(NSRC)) u_arb (
    .pend(pend), .prio_flat(prio_flat), .cur_prio(cur_prio),
    .found(found), .win_vec(win_vec), .win_prio(win_prio)
  );

  assign ack_take = ack_i && irq_o;
  assign eoi_hit  = reg_we && (reg_addr == ADDR_W'(ADR_EOI));
  assign cur_hit  = reg_we && (reg_addr == ADDR_W'(ADR_CUR));

  intc_prio_stack #(.DEPTH(LEVELS)) u_stack (
    .clk(clk), .rst(rst), .push(ack_take), .push_data(cur_prio),
    .pop(eoi_hit && !ack_take), .top(stk_top), .empty(stk_empty)
  );

  always_ff @(posedge clk) begin
    if (rst)
      cur_prio <= '0;
    else if (ack_take)
      cur_prio <= irq_prio_o;
    else if (eoi_hit)
      cur_prio <= stk_top;
    else if (cur_hit)
      cur_prio <= reg_wdata[PRIO_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o      <= 1'b0;
      irq_vec_o  <= '0;
      irq_prio_o <= '0;
    end else begin
      irq_o      <= found;
      irq_vec_o  <= found ? win_vec : '0;
      irq_prio_o <= found ? win_prio : '0;
    end
  end

  assign cur_prio_o = cur_prio;

  // R1: a presented request lies strictly above the level it was judged against
  a_r1_above_level: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (irq_prio_o > $past(cur_prio)));
  // R3: level 0 never reaches the core
  a_r3_zero_silent: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> (irq_prio_o != '0));
  // R4: accepted request becomes the current level
  a_r4_ack_raises: assert property (@(posedge clk) disable iff (rst)
    ack_take |=> (cur_prio == $past(irq_prio_o)));
  // R5: return with nothing saved drops to level 0
  a_r5_eoi_empty: assert property (@(posedge clk) disable iff (rst)
    (eoi_hit && !ack_take && stk_empty) |=> (cur_prio == '0));
endmodule

// File: tb/prio_intc_tb.sv
`timescale 1ns/1ps
module prio_intc_tb;
  localparam int NUM_HW = 8;
  localparam int NUM_SW = 4;

  typedef struct {
    string      tag;
    logic       irq;
    logic [3:0] vec;
    logic [3:0] prio;
    logic [3:0] cur;
  } exp_t;

  logic clk = 0;
  logic rst = 1;
  logic [NUM_HW-1:0] hw_req = '0;
  logic nmi = 0, we = 0, ack = 0;
  logic [5:0] addr = '0;
  logic [3:0] wdata = '0;
  logic irq_o, nmi_o;
  logic [3:0] vec_o, prio_o, cur_o;

  int checks = 0, errors = 0;
  exp_t exp_q[$];

  always #4 clk = ~clk;

  prio_intc #(.NUM_HW(NUM_HW), .NUM_SW(NUM_SW)) u_dut (
    .clk(clk), .rst(rst), .hw_req_i(hw_req), .nmi_i(nmi),
    .reg_we(we), .reg_addr(addr), .reg_wdata(wdata), .ack_i(ack),
    .irq_o(irq_o), .irq_vec_o(vec_o), .irq_prio_o(prio_o),
    .cur_prio_o(cur_o), .nmi_o(nmi_o)
  );

  // Monitor: pops expected items and compares at the falling edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (irq_o !== e.irq || (e.irq && (vec_o !== e.vec || prio_o !== e.prio)) || cur_o !== e.cur) begin
        errors++;
        $display("FAIL %s: got irq=%0b vec=%0d prio=%0d cur=%0d, expected irq=%0b vec=%0d prio=%0d cur=%0d",
                 e.tag, irq_o, vec_o, prio_o, cur_o, e.irq, e.vec, e.prio, e.cur);
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [3:0] d);
    @(negedge clk); #1;
    we = 1; addr = a; wdata = d;
    @(posedge clk); #1;
    we = 0;
  endtask

  task automatic do_ack();
    @(negedge clk); #1;
    ack = 1;
    @(posedge clk); #1;
    ack = 0;
  endtask

  task automatic expect_st(input string tag, input logic i, input logic [3:0] v,
                           input logic [3:0] p, input logic [3:0] c);
    exp_t e;
    repeat (3) @(posedge clk);
    e.tag = tag; e.irq = i; e.vec = v; e.prio = p; e.cur = c;
    exp_q.push_back(e);
    @(negedge clk); #1;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    summary();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 0;
    expect_st("R10 reset state", 0, 0, 0, 0);

    @(negedge clk); #1 hw_req[3] = 1;
    expect_st("R3 zero priority silent", 0, 0, 0, 0);

    wr(6'h13, 4'd5);
    expect_st("R7/R1 source 3 at 5", 1, 3, 5, 0);

    wr(6'h15, 4'd5);
    @(negedge clk); #1 hw_req[5] = 1;
    expect_st("R2 tie lowest index", 1, 3, 5, 0);

    wr(6'h16, 4'd9);
    @(negedge clk); #1 hw_req[6] = 1;
    expect_st("R1 higher source 6", 1, 6, 9, 0);

    wr(6'h00, 4'd9);
    expect_st("R6 ceiling equal masks", 0, 0, 0, 9);
    wr(6'h00, 4'd8);
    expect_st("R6 ceiling below passes", 1, 6, 9, 8);
    wr(6'h00, 4'd0);

    do_ack();
    expect_st("R4 ack raises level", 0, 0, 0, 9);

    wr(6'h19, 4'd12);
    wr(6'h02, 4'b0010);
    expect_st("R8 software source 9", 1, 9, 12, 9);
    do_ack();
    expect_st("R4 nested ack", 0, 0, 0, 12);

    wr(6'h01, 4'd0);
    expect_st("R5/R8 eoi, sw bit kept", 1, 9, 12, 9);

    wr(6'h03, 4'b0010);
    expect_st("R8 sw clear", 0, 0, 0, 9);

    wr(6'h01, 4'd0);
    expect_st("R5 eoi to base", 1, 6, 9, 0);

    wr(6'h01, 4'd0);
    expect_st("R5 eoi on empty", 1, 6, 9, 0);

    wr(6'h16, 4'd2);
    expect_st("R7 runtime reprioritise, R2 tie", 1, 3, 5, 0);

    @(negedge clk); #1 ack = 1;
    @(negedge clk); #1 ack = 0;
    expect_st("R4 ack taken once", 0, 0, 0, 5);
    wr(6'h01, 4'd0);

    hw_req = '0;
    expect_st("R4 ack when idle ignored (prep)", 0, 0, 0, 0);
    do_ack();
    expect_st("R4 ack when idle ignored", 0, 0, 0, 0);

    hw_req[3] = 1;
    wr(6'h00, 4'd3);
    wr(6'h01, 4'd0);
    expect_st("R6 ceiling write not stacked", 1, 3, 5, 0);

    @(negedge clk); #1 nmi = 1; #1;
    checks++;
    if (nmi_o !== 1'b1) begin
      errors++;
      $display("FAIL R9 nmi high: got %0b expected 1", nmi_o);
    end
    expect_st("R9 nmi leaves arbitration", 1, 3, 5, 0);
    nmi = 0; #1;
    checks++;
    if (nmi_o !== 1'b0) begin
      errors++;
      $display("FAIL R9 nmi low: got %0b expected 0", nmi_o);
    end

    repeat (2) @(posedge clk);
    summary();
  end
endmodule